// File: doc/BRIEF.md
# Serial Conversion-Word Register Port

This block is the device-side serial port for the 16-bit conversion-word register of a converter. A host master drives a serial clock, a data input and an active-low select. The port first takes an 8-bit command byte that names the target register, the transfer direction and the input channel. When that command names the conversion-word register for reading, the port shifts the stored word out MSB first. When it names that register for writing, the port takes in a full word and throws it away. In every other case the port waits for the next command byte.

The converter core hands over each new result as a raw sample with a polarity flag. The port stores it as a straight binary code for unipolar samples or as an offset binary code for bipolar samples, and pulls its ready flag low. A complete read drives the ready flag high again.

All serial inputs are brought into the system clock domain, and edges of the serial clock are detected there. The serial clock must therefore run well below the system clock. The serial clock idles high.

Top module: `dreg_serial_port`

## Requirements
- R1: After reset `dout_en` is 0, `dout` is 0, `drdy_n` is 1, `chan` is 0 and the port waits for a command byte.
- R2: A command byte is 8 bits sampled on rising `sclk`, MSB first. Bits [6:4] are the register select, and the value 3 means the conversion-word register. Bit 3 is 1 for a read and 0 for a write. Bits [1:0] appear on `chan` once the byte is complete. For any other select value the port waits for the next command byte.
- R3: A read shifts out the stored word MSB first. `dout` changes only after a falling `sclk` edge and is stable across the following rising edge. The word is loaded on the first falling edge after the command is decoded.
- R4: A read is complete after 16 rising edges, and `drdy_n` then goes to 1. A `conv_valid` pulse drives `drdy_n` to 0.
- R5: A write to the conversion-word register takes exactly 16 data bits before the port waits for a command byte again, whatever those bits hold.
- R6: Written data is discarded. It changes neither the stored word nor `drdy_n`.
- R7: When `conv_bipolar`=0, the stored word equals `conv_raw` (straight binary, zero scale 0x0000).
- R8: When `conv_bipolar`=1, `conv_raw` is taken as two's complement and stored as offset binary (raw XOR 0x8000, so zero maps to 0x8000).
- R9: When `cs_n` is high, any transfer stops, the port returns to waiting for a command byte and `dout_en` goes to 0. A read aborted this way leaves `drdy_n` unchanged.
- R10: A conversion that arrives during a read does not alter the word being shifted. The next read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low port select |
| din | input | 1 | Serial data from host |
| conv_valid | input | 1 | One-cycle pulse: new conversion result |
| conv_raw | input | WORD_W | Raw conversion result |
| conv_bipolar | input | 1 | 1: raw is two's complement, store offset binary |
| dout | output | 1 | Serial data to host |
| dout_en | output | 1 | Output driver enable (0 = high impedance) |
| drdy_n | output | 1 | Active-low data-ready flag |
| chan | output | 2 | Channel field of the last command byte |

## Verification
The case that is hardest to reach from the ports is a write that must not end early. The 16 discarded bits are made to look exactly like a valid read command followed by more bits. A port that left the write state after 8 bits would decode them as a read. A later genuine read would then return a misaligned word. The bench also aborts a read partway through with `cs_n` and delivers a conversion during a read. Random sample values in both polarities exercise the two output formats.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
  localparam int CMD_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_RD  = 2'd1,
    ST_WR  = 2'd2
  } port_st_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             rd;
    logic [1:0]       ch;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_t c;
    c.sel = b[6:4];
    c.rd  = b[3];
    c.ch  = b[1:0];
    return c;
  endfunction
endpackage

// File: rtl/dreg_edge_sync.sv
module dreg_edge_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{RST_VAL[i]}};
        prev  <= RST_VAL[i];
      end else begin
        chain <= {chain[STAGES-2:0], async_in[i]};
        prev  <= chain[STAGES-1];
      end
    end
    assign sync_out[i] = chain[STAGES-1];
    assign rise[i]     = chain[STAGES-1] & ~prev;
    assign fall[i]     = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/dreg_cmd_fsm.sv
module dreg_cmd_fsm
  import dreg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [SEL_W-1:0] DATA_SEL = 3'd3,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_hi,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             din_s,
  output port_st_t         st,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [1:0]       chan,
  output logic             load_evt,
  output logic             shift_evt,
  output logic             rd_done,
  output logic             wr_done
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] cmd_sr;
  logic [CMD_W-1:0] cmd_next;
  logic             load_pend;
  cmd_t             cmd_dec;

  assign cmd_next = {cmd_sr[CMD_W-2:0], din_s};
  assign cmd_dec  = decode_cmd(cmd_next);

  assign load_evt  = fall_evt && !cs_hi && (st == ST_RD) && load_pend;
  assign shift_evt = fall_evt && !cs_hi && (st == ST_RD) && !load_pend;
  assign rd_done   = rise_evt && !cs_hi && (st == ST_RD) && (bit_cnt == LAST_BIT);
  assign wr_done   = rise_evt && !cs_hi && (st == ST_WR) && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_CMD;
      bit_cnt   <= '0;
      cmd_sr    <= '0;
      chan      <= '0;
      load_pend <= 1'b0;
    end else if (cs_hi) begin
      st        <= ST_CMD;
      bit_cnt   <= '0;
      load_pend <= 1'b0;
    end else begin
      if (load_evt) load_pend <= 1'b0;
      if (rise_evt) begin
        unique case (st)
          ST_CMD: begin
            cmd_sr <= cmd_next;
            if (bit_cnt == LAST_CMD) begin
              bit_cnt <= '0;
              chan    <= cmd_dec.ch;
              if (cmd_dec.sel == DATA_SEL) begin
                st        <= cmd_dec.rd ? ST_RD : ST_WR;
                load_pend <= cmd_dec.rd;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RD, ST_WR: begin
            if (bit_cnt == LAST_BIT) begin
              st      <= ST_CMD;
              bit_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: st <= ST_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/dreg_out_shift.sv
module dreg_out_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_raw,
  input  logic              conv_bipolar,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic              rd_done,
  input  logic              cs_hi,
  output logic [WORD_W-1:0] word_q,
  output logic              dout,
  output logic              dout_en,
  output logic              drdy_n
);
  function automatic logic [WORD_W-1:0] fmt_word(input logic [WORD_W-1:0] raw,
                                                 input logic bip);
    logic [WORD_W-1:0] flip;
    flip = '0;
    flip[WORD_W-1] = bip;
    return raw ^ flip;
  endfunction

  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      sh      <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
      drdy_n  <= 1'b1;
    end else begin
      dout_en <= !cs_hi;
      if (conv_valid) word_q <= fmt_word(conv_raw, conv_bipolar);
      if (load_evt) begin
        dout <= word_q[WORD_W-1];
        sh   <= word_q << 1;
      end else if (shift_evt) begin
        dout <= sh[WORD_W-1];
        sh   <= sh << 1;
      end
      if (conv_valid)   drdy_n <= 1'b0;
      else if (rd_done) drdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/dreg_serial_port.sv
module dreg_serial_port
  import dreg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [SEL_W-1:0] DATA_SEL = 3'd3,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_raw,
  input  logic              conv_bipolar,
  output logic              dout,
  output logic              dout_en,
  output logic              drdy_n,
  output logic [1:0]        chan
);
  logic [2:0] s_sync, s_rise, s_fall;
  logic       cs_hi, rise_evt, fall_evt, din_s;
  port_st_t   st;
  logic [CNT_W-1:0] bit_cnt;
  logic       load_evt, shift_evt, rd_done, wr_done;
  logic [WORD_W-1:0] word_q;

  dreg_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({din, cs_n, sclk}),
    .sync_out(s_sync), .rise(s_rise), .fall(s_fall)
  );

  assign rise_evt = s_rise[0];
  assign fall_evt = s_fall[0];
  assign cs_hi    = s_sync[1];
  assign din_s    = s_sync[2];

  dreg_cmd_fsm #(.WORD_W(WORD_W), .DATA_SEL(DATA_SEL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .din_s(din_s), .st(st), .bit_cnt(bit_cnt),
    .chan(chan), .load_evt(load_evt), .shift_evt(shift_evt),
    .rd_done(rd_done), .wr_done(wr_done)
  );

  dreg_out_shift #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_raw(conv_raw),
    .conv_bipolar(conv_bipolar), .load_evt(load_evt), .shift_evt(shift_evt),
    .rd_done(rd_done), .cs_hi(cs_hi), .word_q(word_q), .dout(dout),
    .dout_en(dout_en), .drdy_n(drdy_n)
  );
endmodule

// File: rtl/dreg_port_chk.sv
module dreg_port_chk
  import dreg_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_hi,
  input logic              rise_evt,
  input logic              fall_evt,
  input port_st_t          st,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              rd_done,
  input logic              wr_done,
  input logic              conv_valid,
  input logic [WORD_W-1:0] word_q,
  input logic              dout,
  input logic              dout_en,
  input logic              drdy_n
);
  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (st == ST_CMD) && (bit_cnt == '0));

  // R9
  cs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi && $past(cs_hi) |=> !dout_en);

  // R4
  rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !conv_valid |=> drdy_n);

  // R4
  conv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> !drdy_n);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(dout));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR) && !cs_hi && !wr_done |=> (st == ST_WR) || cs_hi || $past(cs_hi));

  // R6
  wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR) && !conv_valid |=> $stable(word_q));

  // R3
  rd_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

bind dreg_serial_port dreg_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .rise_evt(rise_evt),
  .fall_evt(fall_evt), .st(st), .bit_cnt(bit_cnt), .rd_done(rd_done),
  .wr_done(wr_done), .conv_valid(conv_valid), .word_q(word_q),
  .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n)
);

// File: tb/dreg_serial_port_test.sv
`timescale 1ns/1ps
module dreg_serial_port_test;
  logic clk = 0, rst_n = 0;
  logic sclk = 1, cs_n = 1, din = 0;
  logic conv_valid = 0, conv_bipolar = 0;
  logic [15:0] conv_raw = '0;
  logic dout, dout_en, drdy_n;
  logic [1:0] chan;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dreg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .conv_valid(conv_valid), .conv_raw(conv_raw), .conv_bipolar(conv_bipolar),
    .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n), .chan(chan)
  );

  function automatic logic [15:0] expect_word(input logic [15:0] raw, input bit bip);
    if (!bip) return raw;
    return 16'(int'($signed(raw)) + 32768);
  endfunction

  function automatic logic [7:0] mk_cmd(input logic [2:0] sel, input bit rd,
                                        input logic [1:0] ch);
    return {1'b0, sel, rd, 1'b0, ch};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer_bit(input logic b, output logic sampled);
    sclk = 0; din = b;
    wait_clk(8);
    sampled = dout;
    sclk = 1;
    wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(v[i], s);
  endtask

  task automatic shift16(input logic [15:0] v, output logic [15:0] got);
    logic s;
    for (int i = 15; i >= 0; i--) begin
      xfer_bit(v[i], s);
      got[i] = s;
    end
  endtask

  task automatic convert(input logic [15:0] raw, input bit bip);
    @(negedge clk);
    conv_raw = raw; conv_bipolar = bip; conv_valid = 1;
    @(negedge clk);
    conv_valid = 0;
    wait_clk(2);
  endtask

  task automatic read_word(output logic [15:0] got);
    send_byte(mk_cmd(3'd3, 1'b1, 2'd0));
    shift16(16'h0000, got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, exp_w, raw;
    bit bip;
    void'($urandom(32'd1357));
    wait_clk(3);
    // R1
    chk(dout_en, 0, "R1 dout_en"); chk(drdy_n, 1, "R1 drdy_n");
    chk(chan, 0, "R1 chan"); chk(dout, 0, "R1 dout");
    rst_n = 1;
    wait_clk(4);

    // R7 unipolar read, also R3 and R4
    convert(16'hA5C3, 0);
    chk(drdy_n, 0, "R4 drdy low after conversion");
    cs_n = 0; wait_clk(6);
    chk(dout_en, 1, "R9 dout_en with cs low");
    read_word(got);
    chk(got, 16'hA5C3, "R7 R3 unipolar word");
    chk(drdy_n, 1, "R4 drdy high after read");

    // R8 bipolar corner values
    convert(16'h0000, 1); read_word(got);
    chk(got, 16'h8000, "R8 bipolar zero");
    convert(16'h8000, 1); read_word(got);
    chk(got, 16'h0000, "R8 bipolar negative full scale");
    convert(16'h7FFF, 1); read_word(got);
    chk(got, 16'hFFFF, "R8 bipolar positive full scale");
    convert(16'h0000, 0); read_word(got);
    chk(got, 16'h0000, "R7 unipolar zero scale");

    // R2 channel field and non-data select
    convert(16'h1234, 0);
    send_byte(mk_cmd(3'd1, 1'b1, 2'd2));
    chk(chan, 2, "R2 chan field");
    chk(drdy_n, 0, "R2 other select leaves data pending");
    send_byte(mk_cmd(3'd3, 1'b1, 2'd1));
    chk(chan, 1, "R2 chan field data cmd");
    shift16(16'h0000, got);
    chk(got, 16'h1234, "R2 read after other select");

    // R5 R6 write whose payload mimics a read command
    convert(16'h5AA5, 0);
    send_byte(mk_cmd(3'd3, 1'b0, 2'd0));
    shift16({mk_cmd(3'd3, 1'b1, 2'd0), 8'hFF}, got);
    chk(drdy_n, 0, "R6 write leaves drdy");
    read_word(got);
    chk(got, 16'h5AA5, "R5 R6 write discarded, full 16 bits consumed");

    // R9 abort a read partway
    convert(16'hC0DE, 0);
    send_byte(mk_cmd(3'd3, 1'b1, 2'd0));
    for (int i = 0; i < 5; i++) begin
      logic s;
      xfer_bit(1'b0, s);
    end
    cs_n = 1; wait_clk(8);
    chk(dout_en, 0, "R9 dout_en after abort");
    chk(drdy_n, 0, "R9 aborted read keeps drdy");
    cs_n = 0; wait_clk(6);
    read_word(got);
    chk(got, 16'hC0DE, "R9 read after abort");

    // R10 conversion during a read
    convert(16'h0F0F, 0);
    send_byte(mk_cmd(3'd3, 1'b1, 2'd0));
    for (int i = 15; i >= 8; i--) begin
      logic s;
      xfer_bit(1'b0, s); got[i] = s;
    end
    convert(16'hF00D, 0);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      xfer_bit(1'b0, s); got[i] = s;
    end
    chk(got, 16'h0F0F, "R10 word unchanged mid-read");
    read_word(got);
    chk(got, 16'hF00D, "R10 next read returns new word");

    // random samples, both polarities
    for (int n = 0; n < 24; n++) begin
      raw = 16'($urandom);
      bip = 1'($urandom);
      exp_w = expect_word(raw, bip);
      convert(raw, bip);
      if ($urandom % 3 == 0) begin
        logic [15:0] junk;
        send_byte(mk_cmd(3'd3, 1'b0, 2'd3));
        shift16(16'($urandom), junk);
      end
      read_word(got);
      chk(got, exp_w, bip ? "R8 random bipolar" : "R7 random unipolar");
      chk(drdy_n, 1, "R4 random drdy");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule